// File: doc/BRIEF.md
# Write-Ack Timed Data Sender

This block is the cache-side sender of an eviction write toward a memory controller. The line is first written beat by beat into a small internal register file. A start pulse then captures a target address and raises a write request. The request stays up until the controller acknowledges it. The acknowledge starts a fixed countdown, and when it ends the sender streams the stored line with a data-valid strobe: one entry per cycle, lowest index first, each entry with its ECC check bits.

The launch offset is fixed for each instance. An instance with an even port index waits 6 cycles, and one with an odd port index waits 8. Both values are parameters. An acknowledge that arrives when no request is outstanding has no effect on the transfer, but it sets a sticky error bit. The ECC bits are stored as they are loaded; the block does not compute them.

Top module: `wack_burst_sender`

## Requirements
- R1: A start pulse sampled while the sender is idle raises `wr_req` in the next cycle. `wr_req` stays high through the cycle in which `wr_ack` is sampled, and `wr_addr` carries the address captured with the start pulse for that whole time.
- R2: `wr_dv` is never high before the acknowledge. If `wr_ack` is sampled high in cycle A while `wr_req` is high, `wr_dv` first goes high in cycle A+N, where N is 6 when `PORT_IDX` is even and 8 when it is odd.
- R3: Once `wr_dv` rises, it stays high for exactly 8 consecutive cycles and then falls.
- R4: On the k-th valid cycle (k from 0 to 7), `wr_data` and `wr_ecc` carry buffer entry k, so the entries go out in ascending index order.
- R5: A load sampled while idle writes `load_data` and `load_ecc` into entry `load_idx`. A load sampled while a request, countdown or burst is in progress is ignored, and the buffer contents do not change.
- R6: A start pulse sampled while not idle is ignored. No new request is issued until the current burst has finished.
- R7: A `wr_ack` sampled while `wr_req` is low sets `ack_err`, which stays set until reset. Such an acknowledge does not change the transfer in progress.
- R8: A synchronous active-high `rst` returns the sender to idle with `wr_req`, `wr_dv` and `ack_err` low. It also clears every buffer entry to zero.
- R9: Out of reset, `wr_req`, `wr_dv` and `ack_err` always carry known values, and `wr_data`/`wr_ecc` are known whenever `wr_dv` is high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| load_en | input | 1 | Write one buffer entry (taken only when idle) |
| load_idx | input | $clog2(BEATS) | Buffer entry to write |
| load_data | input | DW | Data word for the entry |
| load_ecc | input | EW | Check bits for the entry |
| start | input | 1 | Begin a write transfer (taken only when idle) |
| start_addr | input | AW | Target line address for the transfer |
| wr_req | output | 1 | Write request, held until acknowledged |
| wr_addr | output | AW | Address carried with the request |
| wr_ack | input | 1 | Write acknowledge from the controller |
| wr_dv | output | 1 | Write data valid |
| wr_data | output | DW | Write data beat |
| wr_ecc | output | EW | Check bits of the current beat |
| ack_err | output | 1 | Sticky flag: acknowledge with no request outstanding |

## Verification
Suppose the countdown loaded at the acknowledge is off by one. Then the data strobe rises a cycle early or late, and the bench sees it in that cycle. A bad beat index or a buffer corrupted by a load during a transfer shows up as a wrong word on the first affected valid cycle. A state machine that leaves the burst too soon or too late shows up as a strobe that drops early or stays high into a ninth cycle. If the machine takes a start pulse while busy, `wr_req` rises in the cycle after that pulse. If a stray acknowledge disturbs the transfer, `ack_err` or the strobe timing diverges one cycle later. The bench uses two instances, one with an even port index and one with an odd one, so both launch offsets are checked on the same stimulus.

// File: rtl/wab_pkg.sv
package wab_pkg;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_WAIT  = 2'd1,
        ST_DELAY = 2'd2,
        ST_BURST = 2'd3
    } wab_state_e;

    // Launch offset from acknowledge to first valid beat, chosen by port parity.
    function automatic int unsigned launch_gap(input int unsigned port_idx,
                                               input int unsigned even_gap,
                                               input int unsigned odd_gap);
        return (port_idx % 2 == 1) ? odd_gap : even_gap;
    endfunction

endpackage

// File: rtl/wab_linebuf.sv
module wab_linebuf #(
    parameter int unsigned DEPTH = 8,
    parameter int unsigned DW    = 32,
    parameter int unsigned EW    = 7,
    localparam int unsigned IW   = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          we,
    input  logic [IW-1:0] widx,
    input  logic [DW-1:0] wdata,
    input  logic [EW-1:0] wecc,
    input  logic [IW-1:0] ridx,
    output logic [DW-1:0] rdata,
    output logic [EW-1:0] recc
);
    logic [DW-1:0] ent_d [DEPTH];
    logic [EW-1:0] ent_e [DEPTH];

    for (genvar e = 0; e < DEPTH; e++) begin : g_ent
        always_ff @(posedge clk) begin
            if (rst) begin
                ent_d[e] <= '0;
                ent_e[e] <= '0;
            end else if (we && (widx == IW'(e))) begin
                ent_d[e] <= wdata;
                ent_e[e] <= wecc;
            end
        end
    end

    assign rdata = ent_d[ridx];
    assign recc  = ent_e[ridx];
endmodule

// File: rtl/wab_ctrl.sv
module wab_ctrl
    import wab_pkg::*;
#(
    parameter int unsigned BEATS = 8,
    parameter int unsigned GAP   = 6,
    parameter int unsigned AW    = 16,
    localparam int unsigned IW   = (BEATS > 1) ? $clog2(BEATS) : 1,
    localparam int unsigned CW   = $clog2(GAP + 1)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          start,
    input  logic [AW-1:0] start_addr,
    input  logic          wr_ack,
    output logic          wr_req,
    output logic [AW-1:0] wr_addr,
    output logic          wr_dv,
    output logic [IW-1:0] beat,
    output logic          idle,
    output logic          ack_err
);
    wab_state_e    st;
    logic [CW-1:0] cnt;
    logic [AW-1:0] addr_q;
    logic          err_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            st     <= ST_IDLE;
            cnt    <= '0;
            beat   <= '0;
            addr_q <= '0;
            err_q  <= 1'b0;
        end else begin
            if (wr_ack && (st != ST_WAIT)) begin
                err_q <= 1'b1;
            end
            case (st)
                ST_IDLE: begin
                    if (start) begin
                        addr_q <= start_addr;
                        st     <= ST_WAIT;
                    end
                end
                ST_WAIT: begin
                    if (wr_ack) begin
                        cnt <= CW'(GAP - 1);
                        st  <= ST_DELAY;
                    end
                end
                ST_DELAY: begin
                    if (cnt == CW'(1)) begin
                        beat <= '0;
                        st   <= ST_BURST;
                    end else begin
                        cnt <= cnt - CW'(1);
                    end
                end
                ST_BURST: begin
                    if (beat == IW'(BEATS - 1)) begin
                        st <= ST_IDLE;
                    end else begin
                        beat <= beat + IW'(1);
                    end
                end
                default: st <= ST_IDLE;
            endcase
        end
    end

    assign wr_req  = (st == ST_WAIT);
    assign wr_dv   = (st == ST_BURST);
    assign idle    = (st == ST_IDLE);
    assign wr_addr = addr_q;
    assign ack_err = err_q;
endmodule

// File: rtl/wack_burst_sender.sv
module wack_burst_sender #(
    parameter int unsigned PORT_IDX = 0,
    parameter int unsigned DW       = 32,
    parameter int unsigned EW       = 7,
    parameter int unsigned AW       = 16,
    parameter int unsigned BEATS    = 8,
    parameter int unsigned EVEN_GAP = 6,
    parameter int unsigned ODD_GAP  = 8,
    localparam int unsigned IW      = (BEATS > 1) ? $clog2(BEATS) : 1
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          load_en,
    input  logic [IW-1:0] load_idx,
    input  logic [DW-1:0] load_data,
    input  logic [EW-1:0] load_ecc,
    input  logic          start,
    input  logic [AW-1:0] start_addr,
    output logic          wr_req,
    output logic [AW-1:0] wr_addr,
    input  logic          wr_ack,
    output logic          wr_dv,
    output logic [DW-1:0] wr_data,
    output logic [EW-1:0] wr_ecc,
    output logic          ack_err
);
    localparam int unsigned GAP = wab_pkg::launch_gap(PORT_IDX, EVEN_GAP, ODD_GAP);

    logic          idle;
    logic [IW-1:0] beat;

    wab_ctrl #(.BEATS(BEATS), .GAP(GAP), .AW(AW)) u_ctrl (
        .clk(clk), .rst(rst), .start(start), .start_addr(start_addr),
        .wr_ack(wr_ack), .wr_req(wr_req), .wr_addr(wr_addr), .wr_dv(wr_dv),
        .beat(beat), .idle(idle), .ack_err(ack_err)
    );

    // The buffer is writable only between transfers.
    wab_linebuf #(.DEPTH(BEATS), .DW(DW), .EW(EW)) u_buf (
        .clk(clk), .rst(rst), .we(load_en && idle), .widx(load_idx),
        .wdata(load_data), .wecc(load_ecc), .ridx(beat),
        .rdata(wr_data), .recc(wr_ecc)
    );
endmodule

// File: rtl/wab_checker.sv
module wab_checker #(
    parameter int unsigned GAP   = 6,
    parameter int unsigned BEATS = 8,
    parameter int unsigned DW    = 32,
    parameter int unsigned EW    = 7,
    localparam int unsigned GW   = $clog2(GAP + 2),
    localparam int unsigned RW   = $clog2(BEATS + 1)
) (
    input logic          clk,
    input logic          rst,
    input logic          wr_req,
    input logic          wr_ack,
    input logic          wr_dv,
    input logic [DW-1:0] wr_data,
    input logic [EW-1:0] wr_ecc,
    input logic          ack_err
);
    logic [GW-1:0] since_ack;
    logic [RW-1:0] run;

    always_ff @(posedge clk) begin
        if (rst) begin
            since_ack <= '0;
            run       <= '0;
        end else begin
            if (wr_req && wr_ack) begin
                since_ack <= GW'(1);
            end else if ((since_ack != '0) && (since_ack <= GW'(GAP))) begin
                since_ack <= since_ack + GW'(1);
            end
            run <= wr_dv ? run + RW'(1) : '0;
        end
    end

    assert_req_held_R1: assert property (@(posedge clk) disable iff (rst)
        (wr_req && !wr_ack) |=> wr_req);

    assert_launch_offset_R2: assert property (@(posedge clk) disable iff (rst)
        $rose(wr_dv) |-> (since_ack == GW'(GAP)));

    assert_launch_due_R2: assert property (@(posedge clk) disable iff (rst)
        (since_ack == GW'(GAP)) |-> wr_dv);

    assert_burst_not_long_R3: assert property (@(posedge clk) disable iff (rst)
        wr_dv |-> (run < RW'(BEATS)));

    assert_burst_not_short_R3: assert property (@(posedge clk) disable iff (rst)
        (!wr_dv && (run != '0)) |-> (run == RW'(BEATS)));

    assert_data_known_R4: assert property (@(posedge clk) disable iff (rst)
        wr_dv |-> !$isunknown({wr_data, wr_ecc}));

    assert_no_req_in_burst_R6: assert property (@(posedge clk) disable iff (rst)
        !(wr_req && wr_dv));

    assert_err_sticky_R7: assert property (@(posedge clk) disable iff (rst)
        ack_err |=> ack_err);

    assert_ctrl_known_R9: assert property (@(posedge clk) disable iff (rst)
        !$isunknown({wr_req, wr_ack, wr_dv, ack_err}));
endmodule

bind wack_burst_sender wab_checker #(.GAP(GAP), .BEATS(BEATS), .DW(DW), .EW(EW)) u_wab_chk (
    .clk(clk), .rst(rst), .wr_req(wr_req), .wr_ack(wr_ack), .wr_dv(wr_dv),
    .wr_data(wr_data), .wr_ecc(wr_ecc), .ack_err(ack_err)
);

// File: tb/wack_burst_sender_bench.sv
`timescale 1ns/1ps
module wack_burst_sender_bench;
    localparam int DW = 32, EW = 7, AW = 16, BEATS = 8, IW = 3;
    localparam int GAPS [2] = '{6, 8};

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic load_en = 1'b0;
    logic [IW-1:0] load_idx = '0;
    logic [DW-1:0] load_data = '0;
    logic [EW-1:0] load_ecc = '0;
    logic start = 1'b0;
    logic [AW-1:0] start_addr = '0;
    logic wr_ack = 1'b0;

    logic          req_o  [2];
    logic [AW-1:0] addr_o [2];
    logic          dv_o   [2];
    logic [DW-1:0] data_o [2];
    logic [EW-1:0] ecc_o  [2];
    logic          err_o  [2];

    int vectors = 0;
    int miscompares = 0;
    string phase = "R8";

    always #2.5 clk = ~clk;

    wack_burst_sender #(.PORT_IDX(0)) u_wack_burst_sender (
        .clk(clk), .rst(rst), .load_en(load_en), .load_idx(load_idx),
        .load_data(load_data), .load_ecc(load_ecc), .start(start),
        .start_addr(start_addr), .wr_req(req_o[0]), .wr_addr(addr_o[0]),
        .wr_ack(wr_ack), .wr_dv(dv_o[0]), .wr_data(data_o[0]),
        .wr_ecc(ecc_o[0]), .ack_err(err_o[0])
    );

    wack_burst_sender #(.PORT_IDX(3)) u_wack_burst_sender_odd (
        .clk(clk), .rst(rst), .load_en(load_en), .load_idx(load_idx),
        .load_data(load_data), .load_ecc(load_ecc), .start(start),
        .start_addr(start_addr), .wr_req(req_o[1]), .wr_addr(addr_o[1]),
        .wr_ack(wr_ack), .wr_dv(dv_o[1]), .wr_data(data_o[1]),
        .wr_ecc(ecc_o[1]), .ack_err(err_o[1])
    );

    // Reference model: phase of each instance (0 idle, 1 requesting,
    // 2 counting toward launch, 3 streaming), cycles until launch, beats sent.
    int            m_phase [2];
    int            m_until [2];
    int            m_sent  [2];
    logic [AW-1:0] m_addr  [2];
    bit            m_err   [2];
    logic [DW-1:0] m_data  [2][BEATS];
    logic [EW-1:0] m_ecc   [2][BEATS];

    task automatic model_step();
        for (int i = 0; i < 2; i++) begin
            if (rst) begin
                m_phase[i] = 0; m_until[i] = 0; m_sent[i] = 0;
                m_err[i] = 0;
                for (int k = 0; k < BEATS; k++) begin
                    m_data[i][k] = '0; m_ecc[i][k] = '0;
                end
            end else begin
                if (wr_ack && m_phase[i] != 1) m_err[i] = 1;
                if (m_phase[i] == 0) begin
                    if (load_en) begin
                        m_data[i][load_idx] = load_data;
                        m_ecc[i][load_idx]  = load_ecc;
                    end
                    if (start) begin
                        m_addr[i] = start_addr;
                        m_phase[i] = 1;
                    end
                end else if (m_phase[i] == 1) begin
                    if (wr_ack) begin
                        m_phase[i] = 2;
                        m_until[i] = GAPS[i] - 1;
                    end
                end else if (m_phase[i] == 2) begin
                    m_until[i]--;
                    if (m_until[i] == 0) begin
                        m_phase[i] = 3; m_sent[i] = 0;
                    end
                end else begin
                    m_sent[i]++;
                    if (m_sent[i] == BEATS) m_phase[i] = 0;
                end
            end
        end
    endtask

    task automatic compare();
        for (int i = 0; i < 2; i++) begin
            bit bad = 0;
            bit e_req = (m_phase[i] == 1);
            bit e_dv  = (m_phase[i] == 3);
            vectors++;
            if (req_o[i] !== e_req) begin
                bad = 1;
                $display("FAIL %s R1 inst%0d wr_req actual=%b expected=%b t=%0t", phase, i, req_o[i], e_req, $time);
            end
            if (e_req && addr_o[i] !== m_addr[i]) begin
                bad = 1;
                $display("FAIL %s R1 inst%0d wr_addr actual=%h expected=%h", phase, i, addr_o[i], m_addr[i]);
            end
            if (dv_o[i] !== e_dv) begin
                bad = 1;
                $display("FAIL %s R2 inst%0d wr_dv actual=%b expected=%b t=%0t", phase, i, dv_o[i], e_dv, $time);
            end
            if (e_dv && (data_o[i] !== m_data[i][m_sent[i]] || ecc_o[i] !== m_ecc[i][m_sent[i]])) begin
                bad = 1;
                $display("FAIL %s R4 inst%0d beat %0d actual=%h/%h expected=%h/%h", phase, i, m_sent[i],
                         data_o[i], ecc_o[i], m_data[i][m_sent[i]], m_ecc[i][m_sent[i]]);
            end
            if (err_o[i] !== m_err[i]) begin
                bad = 1;
                $display("FAIL %s R7 inst%0d ack_err actual=%b expected=%b", phase, i, err_o[i], m_err[i]);
            end
            if (bad) miscompares++;
        end
    endtask

    // Inputs held since the previous falling edge were sampled at the rising edge.
    task automatic tick();
        @(negedge clk);
        model_step();
        compare();
    endtask

    task automatic idle_n(input int n);
        for (int c = 0; c < n; c++) tick();
    endtask

    task automatic fill(input logic [DW-1:0] base);
        for (int k = 0; k < BEATS; k++) begin
            load_en = 1; load_idx = IW'(k);
            load_data = base + DW'(k * 32'h111); load_ecc = EW'(k * 3 + 1);
            tick();
        end
        load_en = 0;
    endtask

    initial begin
        #1_000_000;
        $display("FAIL R2 watchdog expired, run hung");
        miscompares++;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end

    initial begin
        // R8: reset state
        phase = "R8";
        idle_n(3);
        rst = 0;
        idle_n(2);

        // R5, R1, R2, R3, R4: load, request, late acknowledge, full burst
        phase = "R5";
        fill(32'hA000_0000);
        phase = "R1";
        start = 1; start_addr = 16'h1234; tick(); start = 0;
        idle_n(3);
        phase = "R2";
        wr_ack = 1; tick(); wr_ack = 0;
        phase = "R3";
        idle_n(8);
        // R6, R5: start and load during the transfer are ignored
        phase = "R6";
        start = 1; start_addr = 16'hDEAD;
        load_en = 1; load_idx = 3'd3; load_data = 32'hFFFF_FFFF; load_ecc = 7'h7F;
        tick();
        start = 0; load_en = 0;
        idle_n(14);

        // R4, R5: next burst must still carry the original line
        phase = "R4";
        start = 1; start_addr = 16'h0BEE; tick(); start = 0;
        wr_ack = 1; tick(); wr_ack = 0;   // acknowledge in the first request cycle
        idle_n(20);

        // R7: stray acknowledge while idle sets the sticky flag only
        phase = "R7";
        wr_ack = 1; tick(); wr_ack = 0;
        idle_n(3);
        fill(32'h5500_0000);
        start = 1; start_addr = 16'h4321; tick(); start = 0;
        idle_n(2);
        wr_ack = 1; tick(); wr_ack = 0;
        idle_n(9);
        wr_ack = 1; tick(); wr_ack = 0;   // stray acknowledge during the burst
        idle_n(12);

        // R8: reset in the middle of a transfer clears state and buffer
        phase = "R8";
        start = 1; start_addr = 16'h7777; tick(); start = 0;
        wr_ack = 1; tick(); wr_ack = 0;
        idle_n(7);
        rst = 1; tick(); rst = 0;
        idle_n(2);
        // R9: after reset a new transfer sends the cleared line
        phase = "R9";
        start = 1; start_addr = 16'h0001; tick(); start = 0;
        idle_n(1);
        wr_ack = 1; tick(); wr_ack = 0;
        idle_n(20);

        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end
endmodule